// File: doc/BRIEF.md
# DMA Channel Service Arbiter

This block decides which of several DMA channels holding a pending request is handed to the transfer engine next. It has two arbitration policies chosen by one mode input: a ranked policy, in which each channel carries a group number and a channel priority, and a rotating policy, in which channels take turns. At any moment at most one channel owns the engine. That ownership is reported as a one-hot grant vector, as a binary index and as a valid flag.

While a channel owns the engine under the ranked policy, the block keeps looking for a better-ranked waiting channel. It raises a preemption request when the waiting channel is allowed to displace others, the owner is allowed to be displaced and the challenger outranks the owner. The engine accepts the request with an acknowledge pulse and the grant moves over. Ownership also ends when the engine reports completion.

Two gates hold off new starts. An error arriving while halt-on-error is enabled sets a sticky halted state, which lasts until a clear pulse. A debug stall blocks new starts but lets the owning channel run to completion. Both gates also block preemption, because a preemption is a start.

Top module: `dma_chan_arbiter`

## Requirements
- R1: Under the ranked policy (`rr_mode` = 0), an idle arbiter grants the requesting channel with the highest group number, whatever the channel priorities are. The grant appears after the clock edge at which the request was seen.
- R2: Under the ranked policy, among requesting channels of the same group, the higher channel priority wins. Equal group and priority go to the lower channel index.
- R3: Under the rotating policy (`rr_mode` = 1), the search starts at the channel after the last one granted and wraps from the top index to 0. After reset the search starts at channel 0.
- R4: `grant` is zero or one-hot and matches `active_idx` whenever `active_vld` is 1. It does not change until a completion pulse or an accepted preemption.
- R5: A `done` pulse while a channel is active clears the grant at the next edge. The earliest new grant follows one edge later. `done` while idle has no effect.
- R6: `preempt_req` is high only under the ranked policy, while a channel is active and starts are allowed. The best-ranked waiting channel must have its `preempt_en` bit set, the active channel must have its `yield_en` bit set, and the challenger's {group, priority} must be strictly greater than the owner's.
- R7: `suspend_ack` while `preempt_req` is high moves the grant to the challenger at the next edge. `suspend_ack` without `preempt_req` has no effect.
- R8: `err` while `halt_en` is 1 sets `halted` at the next edge. No channel starts or preempts in that cycle, nor while `halted` is 1. `halt_clr` clears `halted`, and `err` wins over a clear in the same cycle.
- R9: `err` while `halt_en` is 0 leaves `halted` and arbitration unchanged.
- R10: While `dbg_stall` is 1, no channel starts or preempts, and an active channel keeps its grant until `done`.
- R11: After reset, `grant` is 0, `active_vld` is 0, `halted` is 0 and `preempt_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req | input | NCH | Pending service request per channel |
| grp_cfg | input | NCH*GRP_W | Group number per channel, channel i at bits [i*GRP_W +: GRP_W] |
| pri_cfg | input | NCH*PRI_W | Channel priority per channel, channel i at bits [i*PRI_W +: PRI_W] |
| yield_en | input | NCH | Channel may be displaced by a better-ranked channel |
| preempt_en | input | NCH | Channel may displace a worse-ranked owner |
| rr_mode | input | 1 | 1 selects the rotating policy, 0 the ranked policy |
| halt_en | input | 1 | Enables halting on error |
| err | input | 1 | Error report from the engine |
| halt_clr | input | 1 | Clears the halted state |
| dbg_stall | input | 1 | Blocks new starts while high |
| done | input | 1 | Completion pulse for the active channel |
| suspend_ack | input | 1 | Engine accepts a pending preemption |
| grant | output | NCH | One-hot grant of the active channel |
| active_idx | output | clog2(NCH) | Index of the active channel |
| active_vld | output | 1 | A channel owns the engine |
| preempt_req | output | 1 | Preemption requested toward the engine |
| halted | output | 1 | Sticky halt-on-error state |

## Verification
The bench builds the arbiter with five channels, two group bits and two priority bits. The channel count is not a power of two, so the rotating search has to wrap at a count that no index width hides. With only four priority values per group, equal ranks and equal priorities across groups are common in random traffic, which exercises the index tie-break and the group-before-priority order. The small key width also makes strict-versus-equal rank comparisons for preemption occur often.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  // index width, never below one bit
  function automatic int unsigned idx_bits(int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

  typedef enum logic {
    ARB_FIXED = 1'b0,
    ARB_ROUND = 1'b1
  } arb_mode_e;

endpackage

// File: rtl/dma_arb_fixed_pick.sv
module dma_arb_fixed_pick #(
  parameter int unsigned NCH   = 8,
  parameter int unsigned KEY_W = 5,
  parameter int unsigned IDX_W = 3
) (
  input  logic [NCH-1:0]       cand,
  input  logic [NCH*KEY_W-1:0] keys,
  output logic                 found,
  output logic [IDX_W-1:0]     idx,
  output logic [KEY_W-1:0]     key
);

  // strict compare keeps the lower index on equal keys
  always_comb begin
    found = 1'b0;
    idx   = '0;
    key   = '0;
    for (int unsigned i = 0; i < NCH; i++) begin
      if (cand[i] && (!found || (keys[i*KEY_W +: KEY_W] > key))) begin
        found = 1'b1;
        idx   = IDX_W'(i);
        key   = keys[i*KEY_W +: KEY_W];
      end
    end
  end

endmodule

// File: rtl/dma_arb_rr_pick.sv
module dma_arb_rr_pick #(
  parameter int unsigned NCH   = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic [NCH-1:0]   cand,
  input  logic [IDX_W-1:0] last,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  int unsigned pos;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    pos   = 0;
    for (int unsigned k = 1; k <= NCH; k++) begin
      pos = 32'(last) + k;
      if (pos >= NCH) pos = pos - NCH;
      if (!found && cand[pos]) begin
        found = 1'b1;
        idx   = IDX_W'(pos);
      end
    end
  end

endmodule

// File: rtl/dma_arb_preempt_chk.sv
module dma_arb_preempt_chk #(
  parameter int unsigned KEY_W = 5
) (
  input  logic             busy,
  input  logic             fixed_mode,
  input  logic             start_ok,
  input  logic             chal_vld,
  input  logic             chal_may,
  input  logic             owner_yields,
  input  logic [KEY_W-1:0] chal_key,
  input  logic [KEY_W-1:0] owner_key,
  output logic             preempt
);

  logic outranks;

  assign outranks = chal_key > owner_key;
  assign preempt  = busy & fixed_mode & start_ok & chal_vld &
                    chal_may & owner_yields & outranks;

endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter
  import dma_arb_pkg::*;
#(
  parameter int unsigned NCH   = 8,
  parameter int unsigned GRP_W = 2,
  parameter int unsigned PRI_W = 3,
  localparam int unsigned IDX_W = idx_bits(NCH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH-1:0]       req,
  input  logic [NCH*GRP_W-1:0] grp_cfg,
  input  logic [NCH*PRI_W-1:0] pri_cfg,
  input  logic [NCH-1:0]       yield_en,
  input  logic [NCH-1:0]       preempt_en,
  input  logic                 rr_mode,
  input  logic                 halt_en,
  input  logic                 err,
  input  logic                 halt_clr,
  input  logic                 dbg_stall,
  input  logic                 done,
  input  logic                 suspend_ack,
  output logic [NCH-1:0]       grant,
  output logic [IDX_W-1:0]     active_idx,
  output logic                 active_vld,
  output logic                 preempt_req,
  output logic                 halted
);

  localparam int unsigned KEY_W = GRP_W + PRI_W;

  // reset: asserted at once, released after two edges
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  // state
  logic             busy_q, busy_d;
  logic [IDX_W-1:0] act_q, act_d;
  logic [IDX_W-1:0] last_q, last_d;
  logic             halt_q, halt_d;
  logic             own_en, halt_ff_en;

  // rank keys: group above priority
  logic [NCH*KEY_W-1:0] keys;
  logic [NCH-1:0]       act_oh;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    assign keys[g*KEY_W +: KEY_W] = {grp_cfg[g*GRP_W +: GRP_W], pri_cfg[g*PRI_W +: PRI_W]};
    assign act_oh[g] = busy_q && (act_q == IDX_W'(g));
  end

  logic [NCH-1:0]   cand;
  logic             f_found, r_found;
  logic [IDX_W-1:0] f_idx, r_idx;
  logic [KEY_W-1:0] f_key, owner_key;
  arb_mode_e        mode;
  logic             fixed_mode, halt_now, start_ok, pre_w, take_pre;

  assign cand       = req & ~act_oh;
  assign mode       = arb_mode_e'(rr_mode);
  assign fixed_mode = (mode == ARB_FIXED);
  assign halt_now   = halt_q | (err & halt_en);
  assign start_ok   = ~halt_now & ~dbg_stall;
  assign owner_key  = keys[32'(act_q)*KEY_W +: KEY_W];

  dma_arb_fixed_pick #(.NCH(NCH), .KEY_W(KEY_W), .IDX_W(IDX_W)) u_fixed (
    .cand  (cand),
    .keys  (keys),
    .found (f_found),
    .idx   (f_idx),
    .key   (f_key)
  );

  dma_arb_rr_pick #(.NCH(NCH), .IDX_W(IDX_W)) u_rr (
    .cand  (cand),
    .last  (last_q),
    .found (r_found),
    .idx   (r_idx)
  );

  dma_arb_preempt_chk #(.KEY_W(KEY_W)) u_pre (
    .busy         (busy_q),
    .fixed_mode   (fixed_mode),
    .start_ok     (start_ok),
    .chal_vld     (f_found),
    .chal_may     (preempt_en[f_idx]),
    .owner_yields (yield_en[act_q]),
    .chal_key     (f_key),
    .owner_key    (owner_key),
    .preempt      (pre_w)
  );

  assign take_pre = pre_w & suspend_ack;

  // next state
  always_comb begin
    busy_d = busy_q;
    act_d  = act_q;
    last_d = last_q;
    halt_d = halt_q;

    if (err && halt_en)  halt_d = 1'b1;
    else if (halt_clr)   halt_d = 1'b0;

    if (busy_q) begin
      if (done) begin
        busy_d = 1'b0;
      end else if (take_pre) begin
        act_d  = f_idx;
        last_d = f_idx;
      end
    end else if (start_ok) begin
      if (fixed_mode && f_found) begin
        busy_d = 1'b1;
        act_d  = f_idx;
        last_d = f_idx;
      end else if (!fixed_mode && r_found) begin
        busy_d = 1'b1;
        act_d  = r_idx;
        last_d = r_idx;
      end
    end
  end

  assign own_en     = busy_q ? (done | take_pre)
                             : (start_ok & (fixed_mode ? f_found : r_found));
  assign halt_ff_en = (err & halt_en) | halt_clr;

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      busy_q <= 1'b0;
      act_q  <= '0;
      last_q <= IDX_W'(NCH - 1);
    end else if (own_en) begin
      busy_q <= busy_d;
      act_q  <= act_d;
      last_q <= last_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)        halt_q <= 1'b0;
    else if (halt_ff_en) halt_q <= halt_d;
  end

  assign grant       = act_oh;
  assign active_idx  = act_q;
  assign active_vld  = busy_q;
  assign preempt_req = pre_w;
  assign halted      = halt_q;

endmodule

// File: rtl/dma_arb_checker.sv
module dma_arb_checker #(
  parameter int unsigned NCH = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] req,
  input logic [NCH-1:0] grant,
  input logic           active_vld,
  input logic           preempt_req,
  input logic           suspend_ack,
  input logic           done,
  input logic           halted,
  input logic           halt_en,
  input logic           err,
  input logic           dbg_stall,
  input logic           rr_mode
);

  p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (active_vld == (grant != '0)));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active_vld && !done && !(preempt_req && suspend_ack)) |=> (active_vld && $stable(grant)));

  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active_vld && done) |=> !active_vld);

  p_start_needs_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !active_vld |=> (!active_vld || (($past(req) & grant) != '0)));

  p_pre_ctx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    preempt_req |-> (active_vld && !rr_mode && !halted && !dbg_stall));

  p_halt_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err && halt_en) |=> halted);

  p_halt_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_vld && halted) |=> !active_vld);

  p_dbg_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_vld && dbg_stall) |=> !active_vld);

endmodule

bind dma_chan_arbiter dma_arb_checker #(.NCH(NCH)) u_arb_chk (
  .clk         (clk),
  .rst_n       (rst_n_s),
  .req         (req),
  .grant       (grant),
  .active_vld  (active_vld),
  .preempt_req (preempt_req),
  .suspend_ack (suspend_ack),
  .done        (done),
  .halted      (halted),
  .halt_en     (halt_en),
  .err         (err),
  .dbg_stall   (dbg_stall),
  .rr_mode     (rr_mode)
);

// File: tb/test_dma_chan_arbiter.sv
module test_dma_chan_arbiter;
  localparam int NCH = 5;
  localparam int GW  = 2;
  localparam int PW  = 2;
  localparam int IW  = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic [NCH-1:0] req, yield_en, preempt_en;
  logic [NCH*GW-1:0] grp_cfg;
  logic [NCH*PW-1:0] pri_cfg;
  logic rr_mode, halt_en, err, halt_clr, dbg_stall, done, suspend_ack;
  logic [NCH-1:0] grant;
  logic [IW-1:0] active_idx;
  logic active_vld, preempt_req, halted;

  int grp_a[NCH];
  int pri_a[NCH];

  always #5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      grp_cfg[i*GW +: GW] = GW'(grp_a[i]);
      pri_cfg[i*PW +: PW] = PW'(pri_a[i]);
    end
  end

  dma_chan_arbiter #(.NCH(NCH), .GRP_W(GW), .PRI_W(PW)) i_dma_chan_arbiter (
    .clk(clk), .rst_n(rst_n), .req(req), .grp_cfg(grp_cfg), .pri_cfg(pri_cfg),
    .yield_en(yield_en), .preempt_en(preempt_en), .rr_mode(rr_mode),
    .halt_en(halt_en), .err(err), .halt_clr(halt_clr), .dbg_stall(dbg_stall),
    .done(done), .suspend_ack(suspend_ack), .grant(grant),
    .active_idx(active_idx), .active_vld(active_vld),
    .preempt_req(preempt_req), .halted(halted)
  );

  int n_chk = 0;
  int n_bad = 0;

  // reference model state
  bit m_busy;
  int m_act;
  int m_last;
  bit m_halt;

  function automatic int mkey(int i);
    return grp_a[i] * (1 << PW) + pri_a[i];
  endfunction

  function automatic int m_best();
    int b = -1;
    for (int i = 0; i < NCH; i++)
      if (req[i] && !(m_busy && i == m_act) && (b < 0 || mkey(i) > mkey(b))) b = i;
    return b;
  endfunction

  function automatic int m_rot();
    for (int k = 1; k <= NCH; k++) begin
      int p = (m_last + k) % NCH;
      if (req[p] && !(m_busy && p == m_act)) return p;
    end
    return -1;
  endfunction

  function automatic bit m_go();
    return !m_halt && !(err && halt_en) && !dbg_stall;
  endfunction

  function automatic bit m_pre();
    int c = m_best();
    return m_busy && !rr_mode && m_go() && c >= 0 && preempt_en[c] &&
           yield_en[m_act] && (mkey(c) > mkey(m_act));
  endfunction

  task automatic cmp(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_all(string tag);
    cmp(tag, "grant", int'(grant), m_busy ? (1 << m_act) : 0);
    cmp(tag, "active_vld", int'(active_vld), int'(m_busy));
    if (m_busy) cmp(tag, "active_idx", int'(active_idx), m_act);
    cmp(tag, "preempt_req", int'(preempt_req), int'(m_pre()));
    cmp(tag, "halted", int'(halted), int'(m_halt));
  endtask

  task automatic model_update();
    bit pre = m_pre();
    int c = m_best();
    int r = m_rot();
    bit go = m_go();
    bit h = m_halt;
    if (err && halt_en) h = 1'b1;
    else if (halt_clr) h = 1'b0;
    if (m_busy) begin
      if (done) m_busy = 1'b0;
      else if (pre && suspend_ack) begin m_act = c; m_last = c; end
    end else if (go) begin
      int p = rr_mode ? r : c;
      if (p >= 0) begin m_busy = 1'b1; m_act = p; m_last = p; end
    end
    m_halt = h;
  endtask

  // inputs already driven at the falling edge
  task automatic step(string tag);
    #1;
    check_all(tag);
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic quiet();
    req = '0; err = 0; halt_clr = 0; done = 0; suspend_ack = 0; dbg_stall = 0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R4 watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NCH; i++) begin grp_a[i] = 0; pri_a[i] = 0; end
    yield_en = '0; preempt_en = '0; rr_mode = 0; halt_en = 1;
    quiet();
    rst_n = 0;
    m_busy = 0; m_act = 0; m_last = NCH - 1; m_halt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R11 reset state
    step("R11");

    // R1 group beats channel priority: ch1 g0 p3, ch4 g2 p0
    grp_a[1] = 0; pri_a[1] = 3; grp_a[4] = 2; pri_a[4] = 0;
    req = 5'b10010;
    step("R1"); step("R1");
    done = 1; step("R5"); done = 0;
    step("R5"); step("R1");
    done = 1; step("R5"); done = 0; req = '0;
    done = 1; step("R5"); done = 0;   // done while idle
    step("R5");

    // R2 same group: ch0 p1, ch2 p2, ch3 p2 -> ch2 wins tie by index
    for (int i = 0; i < NCH; i++) begin grp_a[i] = 1; pri_a[i] = 1; end
    pri_a[2] = 2; pri_a[3] = 2;
    req = 5'b01101;
    step("R2"); step("R2");
    done = 1; step("R2"); done = 0; req = 5'b01001;
    step("R2"); step("R2");
    done = 1; step("R2"); done = 0; req = '0; step("R2");

    // R3 rotating order with wrap
    rr_mode = 1; req = 5'b11111;
    for (int n = 0; n < 7; n++) begin
      step("R3"); step("R3");
      done = 1; step("R3"); done = 0;
    end
    req = 5'b00011;
    for (int n = 0; n < 3; n++) begin
      step("R3"); done = 1; step("R3"); done = 0;
    end
    req = '0; step("R3"); rr_mode = 0;

    // R6 and R7 preemption: ch0 low, ch3 high
    for (int i = 0; i < NCH; i++) begin grp_a[i] = 0; pri_a[i] = 0; end
    grp_a[3] = 1; yield_en = 5'b00001; preempt_en = 5'b00000;
    req = 5'b00001; step("R6"); step("R6");
    req = 5'b01001; step("R6");               // challenger lacks permission
    suspend_ack = 1; step("R7"); suspend_ack = 0;  // ack without request
    preempt_en = 5'b01000; step("R6"); step("R6");
    suspend_ack = 1; step("R7"); suspend_ack = 0;
    step("R7"); step("R7");
    done = 1; step("R7"); done = 0; step("R7");
    done = 1; step("R7"); done = 0; req = '0; step("R7");
    // equal rank does not preempt
    grp_a[3] = 0; req = 5'b00001; step("R6");
    req = 5'b01001; step("R6"); suspend_ack = 1; step("R6"); suspend_ack = 0;
    done = 1; step("R6"); done = 0; req = '0; step("R6");
    done = 1; step("R6"); done = 0; step("R6");

    // R8 halt on error
    halt_en = 1; err = 1; req = 5'b00100; step("R8"); err = 0;
    step("R8"); step("R8");
    err = 1; halt_clr = 1; step("R8"); err = 0;
    step("R8"); step("R8"); halt_clr = 0; step("R8");
    done = 1; step("R8"); done = 0; req = '0; step("R8");

    // R9 error ignored when halting disabled
    halt_en = 0; err = 1; req = 5'b00010; step("R9"); step("R9"); err = 0;
    done = 1; step("R9"); done = 0; req = '0; step("R9");
    halt_en = 1;

    // R10 debug stall
    req = 5'b00001; step("R10"); step("R10");
    dbg_stall = 1; req = 5'b01001; preempt_en = 5'b01000; grp_a[3] = 2;
    step("R10"); step("R10");
    done = 1; step("R10"); done = 0;
    step("R10"); step("R10");
    dbg_stall = 0; step("R10"); step("R10");
    done = 1; step("R10"); done = 0; req = '0; step("R10");

    // R4 mixed random traffic
    for (int n = 0; n < 4000; n++) begin
      if (n % 500 == 0) begin
        for (int i = 0; i < NCH; i++) begin
          grp_a[i] = int'($urandom_range(0, 3));
          pri_a[i] = int'($urandom_range(0, 3));
        end
        yield_en = NCH'($urandom); preempt_en = NCH'($urandom);
        rr_mode = ($urandom_range(0, 2) == 0);
        halt_en = ($urandom_range(0, 1) == 0);
      end
      req         = NCH'($urandom);
      err         = ($urandom_range(0, 60) == 0);
      halt_clr    = ($urandom_range(0, 8) == 0);
      dbg_stall   = ($urandom_range(0, 10) == 0);
      done        = ($urandom_range(0, 4) == 0);
      suspend_ack = ($urandom_range(0, 2) == 0);
      step("R4");
    end
    quiet();
    step("R4");
    finish_run();
  end

endmodule